// File: doc/BRIEF.md
# Two-Byte-Addressed Serial Memory Slave

This block is the bus-side front end of a serial memory that sits on a two-wire I2C bus and uses a 16-bit array address. It brings SCL and SDA into the system clock domain and watches for bus conditions. When SDA changes while SCL is high, it treats a falling SDA as START and a rising SDA as STOP. It then receives the slave address byte and answers only when the byte carries the memory device type and the chip-select value strapped on its pins.

In a write, the master sends the upper and then the lower address byte. Each data byte that follows is stored at the pointer, and the pointer then advances. In a read, the block shifts out the byte at the pointer and keeps going for as long as the master acknowledges. A random read is a write of the address, then a repeated START, then a read.

The open-drain pad stays outside the block. `sda_pull_o` high means the pad must pull SDA low. The storage is a small internal array that the 16-bit pointer indexes modulo its depth.

Top module: `i2c_mem2b_slave`

## Requirements
- R1: After reset, `sda_pull_o` is 0, so SDA is released.
- R2: In the first byte after a START, bits 7:4 are the device type and must equal binary 1010. Any other value gets no ACK on the 9th clock, and the block ignores the bus until the next START.
- R3: Bits 3:1 of the first byte must equal `chip_sel_i`, with bit 3 matched against `chip_sel_i[2]`. A mismatch gets no ACK.
- R4: The block acknowledges a matching slave address byte, both array address bytes and every write data byte. It holds SDA low through the high phase of the 9th SCL clock.
- R5: Bit 0 of the first byte selects the direction, 0 for write and 1 for read. After a write address, the next byte is the upper 8 bits of the pointer and the byte after that is the lower 8 bits. Each further byte is stored at the pointer, and the pointer then increments.
- R6: After a read address, the block shifts out the byte at the pointer MSB first, one bit per SCL clock, and increments the pointer once per byte. It continues with the next byte while the master acknowledges.
- R7: A master NACK on the 9th clock of a read byte ends the read. The block keeps SDA released, even for clocks that follow, until the next START.
- R8: The pointer is 16 bits wide and wraps from 0xFFFF to 0x0000, in both writes and reads. The storage location is the pointer modulo `MEM_DEPTH`.
- R9: A repeated START at any point returns the block to the slave-address phase and keeps the pointer, which allows a random read.
- R10: A STOP at any point aborts the transfer. Bytes clocked after it without a new START get no ACK.
- R11: Apart from the release forced by START or STOP, `sda_pull_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (the wired-AND level) |
| chip_sel_i | input | 3 | Strapped chip-select value compared with address bits 3:1 |
| sda_pull_o | output | 1 | 1 tells the open-drain pad to pull SDA low |

## Verification
The bench builds the block with its defaults: `MEM_DEPTH` = 64 and `SYNC_STAGES` = 2. With only 64 storage locations, addresses 0xFFFF and 0x0000 land on the last and first entries. The pointer wrap can therefore be checked byte for byte by reading back across the boundary. Far-apart addresses in the vector table map onto distinct small locations. With two synchronizer stages, the slave reacts about four system clocks after each SCL edge. That is well inside a bus quarter-period of five clocks, so acknowledge timing and the rule that the slave drives SDA only while SCL is low can both be observed at the pins.

// File: rtl/i2c_mem2b_pkg.sv
package i2c_mem2b_pkg;
  localparam int unsigned PTR_W = 16;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_e;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic                   scl_d, sda_d;

  // bus lines idle high, so registers reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[LAST];
      sda_d  <= sda_sh[LAST];
    end
  end

  assign scl_lvl   = scl_sh[LAST];
  assign sda_lvl   = sda_sh[LAST];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_mem2b_store.sv
module i2c_mem2b_store #(
  parameter int unsigned DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_mem2b_engine.sv
module i2c_mem2b_engine
  import i2c_mem2b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [2:0]       chip_sel_i,
  input  logic [7:0]       rd_data,
  output phase_e           phase,
  output logic [3:0]       bit_cnt,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  localparam logic [3:0] CNT_BYTE = 4'd8;
  localparam logic [3:0] CNT_ACK  = 4'd9;

  phase_e           phase_q, phase_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       shr_q, shr_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             pull_q, pull_d;
  logic             rw_q, rw_d;
  logic             mack_q, mack_d;
  logic             dev_hit;
  logic             do_load;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    shr_d   = shr_q;
    ptr_d   = ptr_q;
    pull_d  = pull_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    do_load = 1'b0;
    dev_hit = (shr_q[7:4] == DEV_TYPE) && (shr_q[3:1] == chip_sel_i);

    if (bus_start) begin
      phase_d = PH_DEV;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (bus_stop) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < CNT_BYTE) begin
          cnt_d = cnt_q + 4'd1;
          if (phase_q != PH_RD) shr_d = {shr_q[6:0], sda_lvl};
        end else if (cnt_q == CNT_BYTE) begin
          cnt_d  = CNT_ACK;
          mack_d = ~sda_lvl;
        end
      end else if (scl_fall) begin
        if (cnt_q == CNT_BYTE) begin
          unique case (phase_q)
            PH_DEV: begin
              if (dev_hit) begin
                pull_d = 1'b1;
                rw_d   = shr_q[0];
              end else begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
              end
            end
            PH_AHI: begin
              pull_d = 1'b1;
              ptr_d  = {shr_q, ptr_q[7:0]};
            end
            PH_ALO: begin
              pull_d = 1'b1;
              ptr_d  = {ptr_q[PTR_W-1:8], shr_q};
            end
            PH_WR: begin
              pull_d = 1'b1;
              wr_en  = 1'b1;
              ptr_d  = ptr_q + 1'b1;
            end
            PH_RD:   pull_d = 1'b0;
            default: ;
          endcase
        end else if (cnt_q == CNT_ACK) begin
          cnt_d  = '0;
          pull_d = 1'b0;
          unique case (phase_q)
            PH_DEV: begin
              if (rw_q) do_load = 1'b1;
              else      phase_d = PH_AHI;
            end
            PH_AHI: phase_d = PH_ALO;
            PH_ALO: phase_d = PH_WR;
            PH_RD: begin
              if (mack_q) do_load = 1'b1;
              else        phase_d = PH_IDLE;
            end
            default: ;
          endcase
          if (do_load) begin
            phase_d = PH_RD;
            shr_d   = rd_data;
            ptr_d   = ptr_q + 1'b1;
            pull_d  = ~rd_data[7];
          end
        end else if (phase_q == PH_RD && cnt_q != '0) begin
          shr_d  = {shr_q[6:0], 1'b0};
          pull_d = ~shr_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      shr_q   <= shr_d;
      ptr_q   <= ptr_d;
      pull_q  <= pull_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign phase    = phase_q;
  assign bit_cnt  = cnt_q;
  assign ptr      = ptr_q;
  assign wr_data  = shr_q;
  assign sda_pull = pull_q;
endmodule

// File: rtl/i2c_mem2b_slave.sv
module i2c_mem2b_slave
  import i2c_mem2b_pkg::*;
#(
  parameter int unsigned MEM_DEPTH   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel_i,
  output logic       sda_pull_o
);
  localparam int unsigned MEM_AW = $clog2(MEM_DEPTH);

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  phase_e           phase;
  logic [3:0]       bit_cnt;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [7:0]       wr_data, rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  i2c_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk      (clk),
    .rst_n    (rst_sn),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  i2c_mem2b_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_sn),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .chip_sel_i(chip_sel_i),
    .rd_data   (rd_data),
    .phase     (phase),
    .bit_cnt   (bit_cnt),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sda_pull  (sda_pull_o)
  );

  i2c_mem2b_store #(.DEPTH(MEM_DEPTH)) u_store (
    .clk  (clk),
    .we   (wr_en),
    .addr (ptr[MEM_AW-1:0]),
    .wdata(wr_data),
    .rdata(rd_data)
  );
endmodule

// File: rtl/i2c_mem2b_chk.sv
module i2c_mem2b_chk
  import i2c_mem2b_pkg::*;
(
  input logic             clk,
  input logic             rst_sn,
  input logic             scl_lvl,
  input logic             bus_start,
  input logic             bus_stop,
  input phase_e           phase,
  input logic [3:0]       bit_cnt,
  input logic [PTR_W-1:0] ptr,
  input logic             wr_en,
  input logic             sda_pull_o
);
  // R11: slave drive moves only in the SCL low phase or on a bus condition
  p_pull_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(sda_pull_o) |-> $past(!scl_lvl || bus_start || bus_stop));

  // R4: SDA is pulled only inside an addressed transfer
  p_pull_only_selected_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    sda_pull_o |-> phase != PH_IDLE);

  // R8: each stored byte advances the 16-bit pointer modulo 2^16
  p_ptr_advance_wrap_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en |=> ptr == $past(ptr) + 16'd1);

  // R9: START returns to the slave-address phase
  p_start_to_address_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_start |=> (phase == PH_DEV) && (bit_cnt == 4'd0));

  // R10: STOP aborts and releases SDA
  p_stop_aborts_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_stop |=> (phase == PH_IDLE) && !sda_pull_o);
endmodule

bind i2c_mem2b_slave i2c_mem2b_chk u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .scl_lvl   (scl_lvl),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .phase     (phase),
  .bit_cnt   (bit_cnt),
  .ptr       (ptr),
  .wr_en     (wr_en),
  .sda_pull_o(sda_pull_o)
);

// File: tb/sim_i2c_mem2b_slave.sv
module sim_i2c_mem2b_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WATCHDOG   = 150000;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, CS, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, CS, 1'b1};
  localparam int NVEC = 6;
  // {address, data written, data expected back}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h1234, 8'hC3, 8'hC3},
    {16'h0005, 8'h7E, 8'h7E},
    {16'hABCD, 8'h01, 8'h01},
    {16'h8000, 8'hFF, 8'hFF},
    {16'h0021, 8'h00, 8'h00},
    {16'h7FFE, 8'h96, 8'h96}
  };

  logic clk, rst_n, m_scl, m_sda, sda_pull_o, pull_prev;
  wire  sda_line = m_sda & ~sda_pull_o;
  int   n_chk, n_fail, bad_moves;

  i2c_mem2b_slave u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .chip_sel_i(CS),
    .sda_pull_o(sda_pull_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // R11 monitor: slave must not move SDA while master holds SCL high
  initial begin
    pull_prev = 1'b0;
    bad_moves = 0;
    forever begin
      @(negedge clk); #1;
      if (rst_n && m_scl && sda_pull_o != pull_prev) bad_moves++;
      pull_prev = sda_pull_o;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b0; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b1; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(1);
      m_scl = 1'b1; wq(2);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    ack = ~sda_line; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      m_scl = 1'b1; wq(1);
      b[i] = sda_line; wq(1);
      m_scl = 1'b0;
    end
    wq(1);
    m_sda = ~master_ack; wq(1);
    m_scl = 1'b1; wq(2);
    m_scl = 1'b0; wq(1);
    m_sda = 1'b1;
  endtask

  task automatic set_pointer(input logic [15:0] a);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack);   check(ack, "R4 slave address ack", ack, 1);
    send_byte(a[15:8], ack); check(ack, "R4 high address ack", ack, 1);
    send_byte(a[7:0], ack);  check(ack, "R4 low address ack", ack, 1);
  endtask

  task automatic start_read();
    logic ack;
    bus_start();
    send_byte(DEV_R, ack); check(ack, "R9 read address ack after repeated START", ack, 1);
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    n_chk = 0; n_fail = 0;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(sda_pull_o == 1'b0, "R1 released in reset", sda_pull_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_pull_o == 1'b0, "R1 released after reset", sda_pull_o, 0);

    // vector table: write one byte, random-read it back (R5, R6, R9)
    for (int v = 0; v < NVEC; v++) begin
      set_pointer(VEC[v][31:16]);
      send_byte(VEC[v][15:8], ack); check(ack, "R4 write data ack", ack, 1);
      bus_stop();
      set_pointer(VEC[v][31:16]);
      start_read();
      recv_byte(1'b0, rb);
      bus_stop();
      check(rb == VEC[v][7:0], "R5 R9 byte read back at address", rb, VEC[v][7:0]);
    end

    // R2: wrong device type
    bus_start();
    send_byte({4'b1011, CS, 1'b0}, ack);
    check(!ack, "R2 wrong device type not acked", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 ignored until next START", ack, 0);
    bus_stop();

    // R3: wrong chip select
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, ack);
    check(!ack, "R3 chip select mismatch not acked", ack, 0);
    bus_stop();

    // R5 R6: sequential write then sequential read
    set_pointer(16'h0010);
    send_byte(8'h11, ack); check(ack, "R5 seq write 0", ack, 1);
    send_byte(8'h22, ack); check(ack, "R5 seq write 1", ack, 1);
    send_byte(8'h33, ack); check(ack, "R5 seq write 2", ack, 1);
    bus_stop();
    set_pointer(16'h0010);
    start_read();
    recv_byte(1'b1, rb); check(rb == 8'h11, "R6 seq read 0", rb, 8'h11);
    recv_byte(1'b1, rb); check(rb == 8'h22, "R6 seq read 1", rb, 8'h22);
    recv_byte(1'b0, rb); check(rb == 8'h33, "R6 seq read 2", rb, 8'h33);

    // R7: after master NACK, further clocks see SDA released
    recv_byte(1'b1, rb);
    check(rb == 8'hFF, "R7 no drive after master NACK", rb, 8'hFF);
    bus_stop();

    // R8: pointer wrap 0xFFFF -> 0x0000 on write and read
    set_pointer(16'hFFFF);
    send_byte(8'h5A, ack); check(ack, "R8 write at FFFF", ack, 1);
    send_byte(8'hA5, ack); check(ack, "R8 write after wrap", ack, 1);
    bus_stop();
    set_pointer(16'hFFFF);
    start_read();
    recv_byte(1'b1, rb); check(rb == 8'h5A, "R8 read at FFFF", rb, 8'h5A);
    recv_byte(1'b0, rb); check(rb == 8'hA5, "R8 read wrapped to 0000", rb, 8'hA5);
    bus_stop();

    // R10: STOP mid-address aborts, later bytes not acked
    bus_start();
    send_byte(DEV_W, ack); check(ack, "R10 address ack before STOP", ack, 1);
    send_byte(8'h00, ack);
    bus_stop();
    m_scl = 1'b0; wq(1);
    send_byte(8'h00, ack);
    check(!ack, "R10 no ack after STOP without START", ack, 0);
    m_scl = 1'b1; wq(1);
    bus_stop();

    check(bad_moves == 0, "R11 SDA drive moved while SCL high", bad_moves, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule